// File: doc/BRIEF.md
# Pipelined Add, Subtract and Compare Unit

This block computes integer addition, subtraction and set-less-than on 32-bit words, in signed and unsigned forms, with the second operand taken either from a register or from a sign-extended 16-bit immediate. Subtraction always uses the register operand. Signed addition and subtraction raise an overflow flag when the true result does not fit in 32 bits.

The datapath is a four-stage pipeline. Stage 1 selects the operand, inverts it when subtracting, and forms per-bit kill/propagate/generate terms. Stages 2 and 3 build a prefix tree inside each 8-bit block and produce two candidate block sums, one for each value of the block's incoming carry. The carries between blocks are resolved in parallel with this work. The output register picks one candidate per block, then derives the comparison bit and the overflow flag. The output uses a valid/ready handshake. While the output is held, the whole pipeline freezes, and the input side reports this through its ready signal.

Top module: `ksel_adder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, o_valid is 0 and in_ready is 1.
- R2: With o_ready held at 1, an operation accepted at clock edge k appears with o_valid=1 right after edge k+3, which is the fourth edge counting edge k. A new operation can be accepted on every cycle.
- R3: in_op 2'b00 (and 2'b11, which behaves the same) returns a + y mod 2^32. Here y is the immediate sign-extended from bit 15 when in_use_imm=1, and in_b otherwise.
- R4: in_op 2'b01 returns in_a - in_b mod 2^32. in_use_imm and in_imm have no effect on a subtraction.
- R5: o_ovf is 1 only for a signed (in_signed=1) add or subtract whose true result lies outside [-2^31, 2^31-1]. It is never 1 for unsigned operations or comparisons.
- R6: in_op 2'b10 with in_signed=1 returns 32'd1 when in_a < y as two's-complement numbers, and 32'd0 otherwise. This holds even when the internal subtraction overflows.
- R7: in_op 2'b10 with in_signed=0 returns 32'd1 when in_a < y as unsigned numbers, and 32'd0 otherwise. y is still sign-extended from the immediate when in_use_imm=1.
- R8: While o_valid=1 and o_ready=0, o_result and o_ovf stay stable and in_ready is 0. Every accepted operation is delivered exactly once, in order.
- R9: Carries cross all three 8-bit block boundaries correctly. For example, 0xFFFFFFFF + 1 gives 0, and 0x00FF00FF + 0x00010001 gives 0x01000100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation taken at the next edge when in_valid is 1 |
| in_op | input | 2 | 00 add, 01 subtract, 10 set-less-than, 11 add |
| in_signed | input | 1 | Signed form of the operation |
| in_use_imm | input | 1 | Use the immediate instead of in_b (ignored for subtract) |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second register operand |
| in_imm | input | 16 | Immediate, sign-extended to 32 bits |
| o_valid | output | 1 | Result present |
| o_ready | input | 1 | Consumer takes the result at the next edge |
| o_result | output | 32 | Sum, difference or comparison bit |
| o_ovf | output | 1 | Signed overflow exception flag |

## Verification
The bench targets operands at the signed extremes (0x7FFFFFFF, 0x80000000) and all-ones. Getting the overflow rule wrong there flags unsigned sums, or misses 0 - 0x80000000. A comparison built from the raw sign bit, ignoring overflow, reports 0x80000000 < 0x7FFFFFFF as false. Sums whose carry must ripple through every 8-bit block expose a wrong block-carry resolution or a swapped candidate select as a result that is off by one in a single byte. Subtractions offered with an immediate catch a design that lets the immediate in. A long stream with random output back-pressure catches dropped, duplicated or changing results during a stall.

// File: rtl/ksel_pkg.sv
package ksel_pkg;

  localparam logic [1:0] OPC_ADD = 2'b00;
  localparam logic [1:0] OPC_SUB = 2'b01;
  localparam logic [1:0] OPC_SLT = 2'b10;

  // full decode, used by the operand stage
  typedef struct packed {
    logic negate;
    logic imm_ok;
    logic is_slt;
    logic signed_op;
  } ksel_dec_t;

  // what later stages still need
  typedef struct packed {
    logic is_slt;
    logic signed_op;
  } ksel_tail_t;

  function automatic ksel_dec_t decode_op(input logic [1:0] op, input logic sgn);
    ksel_dec_t d;
    d.negate    = (op == OPC_SUB) || (op == OPC_SLT);
    d.imm_ok    = (op != OPC_SUB);
    d.is_slt    = (op == OPC_SLT);
    d.signed_op = sgn;
    return d;
  endfunction

  // two's-complement overflow from the operand and sum sign bits
  function automatic logic signed_ovf(input logic am, input logic bm, input logic sm);
    return (am == bm) && (sm != am);
  endfunction

endpackage

// File: rtl/ksel_prep.sv
module ksel_prep import ksel_pkg::*; #(
  parameter int W    = 32,
  parameter int IMMW = 16
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [IMMW-1:0] imm,
  input  logic            use_imm,
  input  ksel_dec_t       dec,
  output logic [W-1:0]    p,
  output logic [W-1:0]    g,
  output logic            cin,
  output logic            a_msb,
  output logic            b_msb
);
  logic [W-1:0] imm_ext, opnd, y;

  assign imm_ext = {{(W-IMMW){imm[IMMW-1]}}, imm};
  assign opnd    = (use_imm && dec.imm_ok) ? imm_ext : b;
  assign y       = dec.negate ? ~opnd : opnd;

  // kill is the case !p && !g
  assign p     = a ^ y;
  assign g     = a & y;
  assign cin   = dec.negate;
  assign a_msb = a[W-1];
  assign b_msb = y[W-1];
endmodule

// File: rtl/ksel_block.sv
module ksel_block #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] p,
  input  logic [BW-1:0] g,
  output logic [BW-1:0] pre_g,
  output logic [BW-1:0] pre_p
);
  // inclusive prefix of (g,p) over bits 0..i, log-depth tree
  function automatic logic [2*BW-1:0] prefix_tree(input logic [BW-1:0] gi, input logic [BW-1:0] pi);
    logic [BW-1:0] gg, pp, gn, pn;
    gg = gi;
    pp = pi;
    for (int d = 1; d < BW; d = d * 2) begin
      gn = gg;
      pn = pp;
      for (int i = d; i < BW; i++) begin
        gn[i] = gg[i] | (pp[i] & gg[i-d]);
        pn[i] = pp[i] & pp[i-d];
      end
      gg = gn;
      pp = pn;
    end
    return {gg, pp};
  endfunction

  assign {pre_g, pre_p} = prefix_tree(g, p);
endmodule

// File: rtl/ksel_sums.sv
module ksel_sums #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] p,
  input  logic [BW-2:0] pre_g,
  input  logic [BW-2:0] pre_p,
  output logic [BW-1:0] sum0,
  output logic [BW-1:0] sum1
);
  logic [BW-1:0] c_if0, c_if1;

  assign c_if0[0] = 1'b0;
  assign c_if1[0] = 1'b1;
  for (genvar i = 1; i < BW; i++) begin : g_bit
    assign c_if0[i] = pre_g[i-1];
    assign c_if1[i] = pre_g[i-1] | pre_p[i-1];
  end

  assign sum0 = p ^ c_if0;
  assign sum1 = p ^ c_if1;
endmodule

// File: rtl/ksel_resolve.sv
module ksel_resolve #(
  parameter int NB = 4
) (
  input  logic [NB-1:0] grp_g,
  input  logic [NB-1:0] grp_p,
  input  logic          cin0,
  output logic [NB-1:0] bcin,
  output logic          cout
);
  // every block carry-in is formed from group terms only, flattened per block
  function automatic logic carry_into(input int j, input logic [NB-1:0] gg,
                                      input logic [NB-1:0] pp, input logic c0);
    logic acc;
    acc = c0;
    for (int k = 0; k < NB; k++)
      if (k < j) acc = gg[k] | (pp[k] & acc);
    return acc;
  endfunction

  for (genvar j = 0; j < NB; j++) begin : g_cin
    assign bcin[j] = carry_into(j, grp_g, grp_p, cin0);
  end
  assign cout = carry_into(NB, grp_g, grp_p, cin0);
endmodule

// File: rtl/ksel_adder.sv
module ksel_adder import ksel_pkg::*; #(
  parameter int W    = 32,
  parameter int BW   = 8,
  parameter int IMMW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_op,
  input  logic            in_signed,
  input  logic            in_use_imm,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  input  logic [IMMW-1:0] in_imm,
  output logic            o_valid,
  input  logic            o_ready,
  output logic [W-1:0]    o_result,
  output logic            o_ovf
);
  localparam int NB = W / BW;

  logic adv;
  logic q_valid, q_ovf, q_is_slt;
  logic [W-1:0] q_result;

  assign adv      = !q_valid || o_ready;
  assign in_ready = adv;

  // ---------------- stage 1: operand select + kpg ----------------
  ksel_dec_t    dec0;
  logic [W-1:0] p0, g0;
  logic         cin0, am0, bm0;

  assign dec0 = decode_op(in_op, in_signed);

  ksel_prep #(.W(W), .IMMW(IMMW)) u_prep (
    .a(in_a), .b(in_b), .imm(in_imm), .use_imm(in_use_imm), .dec(dec0),
    .p(p0), .g(g0), .cin(cin0), .a_msb(am0), .b_msb(bm0)
  );

  logic         s1_valid, s1_cin, s1_am, s1_bm;
  ksel_tail_t   s1_ctl;
  logic [W-1:0] s1_p, s1_g;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0; s1_ctl <= '0; s1_p <= '0; s1_g <= '0;
      s1_cin <= 1'b0; s1_am <= 1'b0; s1_bm <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_ctl   <= '{is_slt: dec0.is_slt, signed_op: dec0.signed_op};
      s1_p     <= p0;
      s1_g     <= g0;
      s1_cin   <= cin0;
      s1_am    <= am0;
      s1_bm    <= bm0;
    end
  end

  // ---------------- stage 2: in-block prefix tree ----------------
  logic [W-1:0] pre_g, pre_p;
  for (genvar j = 0; j < NB; j++) begin : g_tree
    ksel_block #(.BW(BW)) u_blk (
      .p(s1_p[j*BW +: BW]), .g(s1_g[j*BW +: BW]),
      .pre_g(pre_g[j*BW +: BW]), .pre_p(pre_p[j*BW +: BW])
    );
  end

  logic         s2_valid, s2_cin, s2_am, s2_bm;
  ksel_tail_t   s2_ctl;
  logic [W-1:0] s2_p, s2_G, s2_P;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0; s2_ctl <= '0; s2_p <= '0; s2_G <= '0; s2_P <= '0;
      s2_cin <= 1'b0; s2_am <= 1'b0; s2_bm <= 1'b0;
    end else if (adv) begin
      s2_valid <= s1_valid;
      s2_ctl   <= s1_ctl;
      s2_p     <= s1_p;
      s2_G     <= pre_g;
      s2_P     <= pre_p;
      s2_cin   <= s1_cin;
      s2_am    <= s1_am;
      s2_bm    <= s1_bm;
    end
  end

  // ------- stage 3: dual block sums + parallel block carries -------
  logic [W-1:0]  nx_sum0, nx_sum1;
  logic [NB-1:0] grp_g, grp_p, nx_bcin;
  logic          nx_cout;

  for (genvar j = 0; j < NB; j++) begin : g_sum
    ksel_sums #(.BW(BW)) u_sums (
      .p(s2_p[j*BW +: BW]),
      .pre_g(s2_G[j*BW +: BW-1]), .pre_p(s2_P[j*BW +: BW-1]),
      .sum0(nx_sum0[j*BW +: BW]), .sum1(nx_sum1[j*BW +: BW])
    );
    assign grp_g[j] = s2_G[j*BW + BW-1];
    assign grp_p[j] = s2_P[j*BW + BW-1];
  end

  ksel_resolve #(.NB(NB)) u_res (
    .grp_g(grp_g), .grp_p(grp_p), .cin0(s2_cin), .bcin(nx_bcin), .cout(nx_cout)
  );

  logic          s3_valid, s3_cout, s3_am, s3_bm;
  ksel_tail_t    s3_ctl;
  logic [W-1:0]  s3_sum0, s3_sum1;
  logic [NB-1:0] s3_bcin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_valid <= 1'b0; s3_ctl <= '0; s3_sum0 <= '0; s3_sum1 <= '0;
      s3_bcin <= '0; s3_cout <= 1'b0; s3_am <= 1'b0; s3_bm <= 1'b0;
    end else if (adv) begin
      s3_valid <= s2_valid;
      s3_ctl   <= s2_ctl;
      s3_sum0  <= nx_sum0;
      s3_sum1  <= nx_sum1;
      s3_bcin  <= nx_bcin;
      s3_cout  <= nx_cout;
      s3_am    <= s2_am;
      s3_bm    <= s2_bm;
    end
  end

  // ---------------- stage 4: select, compare, flag ----------------
  logic [W-1:0] s4_sum;
  logic         s4_vraw, s4_lt;

  for (genvar j = 0; j < NB; j++) begin : g_sel
    assign s4_sum[j*BW +: BW] = s3_bcin[j] ? s3_sum1[j*BW +: BW] : s3_sum0[j*BW +: BW];
  end

  assign s4_vraw = signed_ovf(s3_am, s3_bm, s4_sum[W-1]);
  assign s4_lt   = s3_ctl.signed_op ? (s4_sum[W-1] ^ s4_vraw) : !s3_cout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0; q_result <= '0; q_ovf <= 1'b0; q_is_slt <= 1'b0;
    end else if (adv) begin
      q_valid  <= s3_valid;
      q_result <= s3_ctl.is_slt ? {{(W-1){1'b0}}, s4_lt} : s4_sum;
      q_ovf    <= s3_valid && !s3_ctl.is_slt && s3_ctl.signed_op && s4_vraw;
      q_is_slt <= s3_valid && s3_ctl.is_slt;
    end
  end

  assign o_valid  = q_valid;
  assign o_result = q_result;
  assign o_ovf    = q_ovf;
endmodule

// File: rtl/ksel_adder_chk.sv
module ksel_adder_chk #(
  parameter int W  = 32,
  parameter int BW = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         o_valid,
  input logic         o_ready,
  input logic [W-1:0] o_result,
  input logic         o_ovf,
  input logic         q_is_slt,
  input logic         s3_valid,
  input logic [W-1:0] s3_sum0,
  input logic [W-1:0] s3_sum1
);
  localparam int NB = W / BW;

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !o_valid);

  a_r5_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    o_ovf |-> o_valid);

  // R6 / R7: comparison yields a single bit and never flags
  a_r6_slt_binary: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && q_is_slt) |-> (o_result[W-1:1] == '0) && !o_ovf);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> o_valid && $stable(o_result) && $stable(o_ovf));

  // R9: the carry-in-1 candidate of every block is the carry-in-0 candidate plus one
  for (genvar j = 0; j < NB; j++) begin : g_blk
    a_r9_dual_sum: assert property (@(posedge clk) disable iff (!rst_n)
      s3_valid |-> (s3_sum1[j*BW +: BW] ==
                    (s3_sum0[j*BW +: BW] + {{(BW-1){1'b0}}, 1'b1})));
  end
endmodule

bind ksel_adder ksel_adder_chk #(.W(W), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .o_valid(o_valid), .o_ready(o_ready),
  .o_result(o_result), .o_ovf(o_ovf), .q_is_slt(q_is_slt),
  .s3_valid(s3_valid), .s3_sum0(s3_sum0), .s3_sum1(s3_sum1)
);

// File: tb/ksel_adder_test.sv
`timescale 1ns/1ps
module ksel_adder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [1:0]  in_op = 2'b00;
  logic        in_signed = 1'b0, in_use_imm = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [15:0] in_imm = '0;
  logic        o_valid, o_ready = 1'b1, o_ovf;
  logic [31:0] o_result;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ksel_adder uut (.*);

  typedef struct packed {
    logic [1:0]  op; logic sgn; logic ui;
    logic [31:0] a; logic [31:0] b; logic [15:0] imm;
    logic [31:0] er; logic ev;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{2'b00,1'b0,1'b0,32'h5,32'h7,16'h0,32'hC,1'b0},                          // R3
    '{2'b00,1'b1,1'b0,32'h7FFFFFFF,32'h1,16'h0,32'h80000000,1'b1},            // R5
    '{2'b00,1'b0,1'b0,32'hFFFFFFFF,32'h1,16'h0,32'h0,1'b0},                   // R9
    '{2'b00,1'b1,1'b1,32'h10,32'hDEAD,16'hFFFF,32'hF,1'b0},                   // R3 imm
    '{2'b01,1'b1,1'b0,32'h80000000,32'h1,16'h0,32'h7FFFFFFF,1'b1},            // R5
    '{2'b01,1'b0,1'b0,32'h3,32'h5,16'h0,32'hFFFFFFFE,1'b0},                   // R4
    '{2'b01,1'b1,1'b1,32'hA,32'h2,16'h0100,32'h8,1'b0},                       // R4 imm ignored
    '{2'b10,1'b1,1'b0,32'hFFFFFFFF,32'h1,16'h0,32'h1,1'b0},                   // R6
    '{2'b10,1'b0,1'b0,32'hFFFFFFFF,32'h1,16'h0,32'h0,1'b0},                   // R7
    '{2'b10,1'b1,1'b0,32'h80000000,32'h7FFFFFFF,16'h0,32'h1,1'b0},            // R6 overflowing compare
    '{2'b10,1'b0,1'b1,32'h5,32'h0,16'hFFFF,32'h1,1'b0},                       // R7 imm
    '{2'b11,1'b1,1'b0,32'h00FF00FF,32'h00010001,16'h0,32'h01000100,1'b0},     // R9, R3 op 11
    '{2'b01,1'b1,1'b0,32'h0,32'h80000000,16'h0,32'h80000000,1'b1},            // R5
    '{2'b10,1'b1,1'b0,32'h7,32'h7,16'h0,32'h0,1'b0},                          // R6 equal
    '{2'b00,1'b1,1'b0,32'h80000000,32'h80000000,16'h0,32'h0,1'b1},            // R5
    '{2'b00,1'b0,1'b0,32'h7FFFFFFF,32'h1,16'h0,32'h80000000,1'b0}             // R5 unsigned
  };

  // independent behavioural model: {overflow, result}
  function automatic logic [32:0] model(input logic [1:0] op, input logic sgn, input logic ui,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [15:0] imm);
    logic [31:0] y, r;
    logic v;
    longint sr;
    y = (ui && op != 2'b01) ? {{16{imm[15]}}, imm} : b;
    v = 1'b0;
    if (op == 2'b01) begin
      r  = a - y;
      sr = longint'($signed(a)) - longint'($signed(y));
      v  = sgn && (sr > 64'sd2147483647 || sr < -64'sd2147483648);
    end else if (op == 2'b10) begin
      r = sgn ? {31'd0, ($signed(a) < $signed(y))} : {31'd0, (a < y)};
    end else begin
      r  = a + y;
      sr = longint'($signed(a)) + longint'($signed(y));
      v  = sgn && (sr > 64'sd2147483647 || sr < -64'sd2147483648);
    end
    return {v, r};
  endfunction

  function automatic string tag_of(input logic [1:0] op, input logic sgn);
    if (op == 2'b01) return "R4";
    if (op == 2'b10) return sgn ? "R6" : "R7";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h7FFFFFFF;
      1: return 32'h80000000;
      2: return 32'hFFFFFFFF;
      3: return 32'h0;
      4: return 32'h1;
      default: return $urandom;
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [32:0] expq[$];

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!o_valid && in_ready, "R1", "during reset valid/ready", {31'd0, o_valid, in_ready}, 33'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!o_valid && in_ready, "R1", "after reset valid/ready", {31'd0, o_valid, in_ready}, 33'd1);

    // R2 latency: accepted at the next edge, visible at the fourth negedge
    in_valid = 1; in_op = 2'b00; in_signed = 0; in_use_imm = 0; in_a = 32'd40; in_b = 32'd2;
    @(negedge clk);
    in_valid = 0;
    for (int k = 1; k <= 4; k++) begin
      if (k < 4) check(!o_valid, "R2", "early valid", {32'd0, o_valid}, 33'd0);
      else check(o_valid && o_result == 32'd42, "R2", "latency result", {o_valid, o_result}, {1'b1, 32'd42});
      if (k < 4) @(negedge clk);
    end
    @(negedge clk);

    // table of directed vectors, one at a time
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int w;
      v = VT[i];
      in_valid = 1; in_op = v.op; in_signed = v.sgn; in_use_imm = v.ui;
      in_a = v.a; in_b = v.b; in_imm = v.imm;
      @(negedge clk);
      in_valid = 0;
      w = 0;
      while (!o_valid && w < 10) begin @(negedge clk); w++; end
      check(o_result == v.er, tag_of(v.op, v.sgn), $sformatf("table[%0d] result", i),
            {1'b0, o_result}, {1'b0, v.er});
      check(o_ovf == v.ev, "R5", $sformatf("table[%0d] flag", i), {32'd0, o_ovf}, {32'd0, v.ev});
      @(negedge clk);
    end

    // R8 stall: result held while consumer refuses it
    o_ready = 0;
    in_valid = 1; in_op = 2'b00; in_signed = 1; in_use_imm = 0; in_a = 32'd1; in_b = 32'd2;
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(o_valid && o_result == 32'd3 && !in_ready, "R8", "held result",
            {o_valid, o_result}, {1'b1, 32'd3});
      @(negedge clk);
    end
    o_ready = 1;
    @(negedge clk);
    check(!o_valid, "R8", "no duplicate after release", {32'd0, o_valid}, 33'd0);

    // random stream with back-pressure (R2, R3..R8)
    for (int c = 0; c < 3000; c++) begin
      bit more;
      more = (c < 2600);
      o_ready = ($urandom % 10) < 7;
      #1;
      if (o_valid && o_ready) begin
        if (expq.size() == 0) begin
          check(0, "R8", "unexpected output", {o_ovf, o_result}, 33'd0);
        end else begin
          logic [32:0] e;
          e = expq.pop_front();
          check({o_ovf, o_result} == e, "R8", "stream result/flag", {o_ovf, o_result}, e);
        end
      end
      in_valid = more && (($urandom % 10) < 7);
      in_op = 2'($urandom); in_signed = 1'($urandom); in_use_imm = 1'($urandom);
      in_a = pick(); in_b = pick(); in_imm = 16'($urandom);
      #1;
      if (in_valid && in_ready)
        expq.push_back(model(in_op, in_signed, in_use_imm, in_a, in_b, in_imm));
      @(negedge clk);
    end
    in_valid = 0;
    check(expq.size() == 0, "R8", "all results delivered", 33'(expq.size()), 33'd0);
    finish_run();
  end
endmodule